// File: doc/BRIEF.md
# Scanline Interrupt and Multiplier Unit

This block follows the picture generator's line sequence and raises an interrupt once a programmable number of rendered lines has passed since the frame began. Once per line, a one-cycle tick arrives at a fixed dot position together with the current line number. The block treats the following line (current + 1) as the line being judged. The first rendered line of a frame restarts the line counter. Every later line advances the counter. When the counter reaches the 8-bit target, a pending flag is set. Whenever rendering is disabled, or the following line falls in vertical blank, the counter and both flags are forced clear.

The CPU sees four byte registers. Through them it sets the target, enables the interrupt, reads a status byte and drives an 8×8 unsigned multiplier. Reading the status byte acknowledges the pending flag. A separate debug output shows the same byte without any side effect. An external interrupt request is merged into the interrupt output.

Top module: `scanline_irq_mul`

## Requirements
- R1: Line state (counter, in-frame, pending) changes only in a cycle where `line_tick_i` is high or the status register is read; the judged line is `line_num_i + 1` modulo 2^LINE_W, so the pre-render line is presented as all-ones and judges as line 0.
- R2: On a tick with `render_en_i` low, or with a judged line of 241 or more, the in-frame flag, counter and pending flag are all cleared; a judged line of 240 stays in frame.
- R3: On a rendering tick while in-frame is clear, in-frame is set, the counter restarts at 0 and pending is cleared.
- R4: On each further rendering tick the counter increments, and pending is set when the new count equals the target register (address 0, write-only); pending then holds until acknowledged or cleared.
- R5: A write to address 1 loads the interrupt enable from data bit 7.
- R6: A read of address 1 returns bit 7 = pending, bit 6 = in-frame, other bits 0, in the same cycle; pending is cleared at the end of that cycle unless a tick sets it in the same cycle, in which case it stays set.
- R7: `peek_o` always carries the status byte, and watching it never clears pending.
- R8: `irq_o` is high exactly when (pending and enable) or `ext_irq_i`.
- R9: Writes to addresses 2 and 3 load unsigned operands A and B; reads of addresses 2 and 3 return the low and high bytes of A×B, valid in the cycle right after the operand write.
- R10: A read of address 0 returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_tick_i | input | 1 | One-cycle pulse at the evaluation dot of each line |
| line_num_i | input | LINE_W | Current line number (pre-render = all ones) |
| render_en_i | input | 1 | Rendering enabled |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| peek_o | output | DATA_W | Status byte, side-effect free |
| ext_irq_i | input | 1 | External interrupt request |
| irq_o | output | 1 | Interrupt output |

## Verification
Read data is combinational, so each register value is due in the same cycle as its address. A tick or register write takes effect on one clock edge, so the status byte, `peek_o` and `irq_o` reflect it one cycle later. Products are due in the cycle right after the operand write, and the acknowledge from a status read shows in the cycle after the read. The bench drives every strobe on a falling edge and samples on the next falling edge, or one nanosecond after driving for combinational reads, so each sample falls in exactly the cycle where the result is due.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [1:0] {
    REG_TARGET = 2'd0,
    REG_CTRL   = 2'd1,
    REG_MUL_LO = 2'd2,
    REG_MUL_HI = 2'd3
  } reg_sel_e;

  localparam int unsigned EN_BIT = 7;
endpackage

// File: rtl/irq_line_ctr.sv
module irq_line_ctr #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned VBL_LINE = 241
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic              ack_i,
  output logic              in_frame_o,
  output logic              pending_o
);
  localparam logic [LINE_W-1:0] VBL = LINE_W'(VBL_LINE);

  logic [LINE_W-1:0] next_line;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              in_q, in_d, pend_q, pend_d;
  logic              set, clr;

  assign next_line = line_i + LINE_W'(1);
  assign cnt_inc   = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    in_d  = in_q;
    set   = 1'b0;
    clr   = 1'b0;
    if (tick_i) begin
      if (!render_i || next_line >= VBL) begin
        in_d  = 1'b0;
        cnt_d = '0;
        clr   = 1'b1;
      end else if (!in_q) begin
        in_d  = 1'b1;
        cnt_d = '0;
        clr   = 1'b1;
      end else begin
        cnt_d = cnt_inc;
        set   = (cnt_inc == target_i);
      end
    end
    // a match in the acknowledge cycle must not be lost
    if (set)              pend_d = 1'b1;
    else if (clr || ack_i) pend_d = 1'b0;
    else                  pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      in_q   <= in_d;
      pend_q <= pend_d;
    end
  end

  assign in_frame_o = in_q;
  assign pending_o  = pend_q;
endmodule

// File: rtl/mul_unit.sv
module mul_unit #(
  parameter int unsigned OP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [OP_W-1:0]   wdata_i,
  output logic [2*OP_W-1:0] prod_o
);
  logic [OP_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a_i) a_q <= wdata_i;
      if (wr_b_i) b_q <= wdata_i;
    end
  end

  assign prod_o = (2*OP_W)'(a_q) * (2*OP_W)'(b_q);
endmodule

// File: rtl/scanline_irq_mul.sv
module scanline_irq_mul
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VBL_LINE = 241
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_tick_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] peek_o,
  input  logic              ext_irq_i,
  output logic              irq_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] target_q;
  logic              en_q;
  logic              in_frame, pending, ack;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      en_q     <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == REG_TARGET) target_q <= wdata_i;
      if (addr_i == REG_CTRL)   en_q     <= wdata_i[EN_BIT];
    end
  end

  assign ack = rd_en_i && (addr_i == REG_CTRL);

  irq_line_ctr #(
    .LINE_W  (LINE_W),
    .CNT_W   (DATA_W),
    .VBL_LINE(VBL_LINE)
  ) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (line_tick_i),
    .line_i    (line_num_i),
    .render_i  (render_en_i),
    .target_i  (target_q),
    .ack_i     (ack),
    .in_frame_o(in_frame),
    .pending_o (pending)
  );

  mul_unit #(.OP_W(DATA_W)) i_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_a_i (wr_en_i && addr_i == REG_MUL_LO),
    .wr_b_i (wr_en_i && addr_i == REG_MUL_HI),
    .wdata_i(wdata_i),
    .prod_o (prod)
  );

  always_comb begin
    status             = '0;
    status[DATA_W-1]   = pending;
    status[DATA_W-2]   = in_frame;
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL:   rdata_o = status;
      REG_MUL_LO: rdata_o = prod[DATA_W-1:0];
      REG_MUL_HI: rdata_o = prod[PROD_W-1:DATA_W];
      default:    rdata_o = '1;
    endcase
  end

  assign peek_o = status;
  assign irq_o  = (pending && en_q) || ext_irq_i;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VBL_LINE = 241
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_tick_i,
  input logic [LINE_W-1:0] line_num_i,
  input logic              render_en_i,
  input logic              rd_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] peek_o,
  input logic              ext_irq_i,
  input logic              irq_o
);
  logic [LINE_W-1:0] judged;
  logic              blank, st_rd;
  assign judged = line_num_i + LINE_W'(1);
  assign blank  = !render_en_i || (judged >= LINE_W'(VBL_LINE));
  assign st_rd  = rd_en_i && addr_i == 2'd1;

  a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_tick_i && !st_rd) |=> $stable(peek_o));

  a_r2_blank_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && blank) |=> (peek_o == '0));

  a_r3_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && !blank && !peek_o[DATA_W-2]) |=> (peek_o[DATA_W-1:DATA_W-2] == 2'b01));

  a_r4_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_o[DATA_W-1] && !line_tick_i && !st_rd) |=> peek_o[DATA_W-1]);

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && !line_tick_i) |=> !peek_o[DATA_W-1]);

  a_r7_peek_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |-> (rdata_o == peek_o));

  a_r8_ext_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_i |-> irq_o);

  a_r8_no_pend_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_irq_i && !peek_o[DATA_W-1]) |-> !irq_o);
endmodule

bind scanline_irq_mul scanline_irq_chk #(
  .DATA_W  (DATA_W),
  .LINE_W  (LINE_W),
  .VBL_LINE(VBL_LINE)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_tick_i(line_tick_i),
  .line_num_i (line_num_i),
  .render_en_i(render_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .peek_o     (peek_o),
  .ext_irq_i  (ext_irq_i),
  .irq_o      (irq_o)
);

// File: tb/test_scanline_irq_mul.sv
`timescale 1ns/1ps
module test_scanline_irq_mul;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [8:0] line = '0;
  logic       render = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, peek;
  logic       ext = 1'b0;
  logic       irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scanline_irq_mul i_scanline_irq_mul (
    .clk_i(clk), .rst_ni(rst_n), .line_tick_i(tick), .line_num_i(line),
    .render_en_i(render), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .peek_o(peek), .ext_irq_i(ext), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick(logic [8:0] l);
    @(negedge clk); tick = 1'b1; line = l;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R7 reset peek", peek, 8'h00);
    chk("R8 reset irq", irq, 1'b0);
    do_rd(2'd1, d);
    chk("R6 reset status", d, 8'h00);
    do_rd(2'd0, d);
    chk("R10 addr0 read", d, 8'hFF);
  endtask

  task automatic t_mul;
    logic [7:0] lo, hi;
    do_wr(2'd2, 8'h12); do_wr(2'd3, 8'h34);
    do_rd(2'd2, lo); do_rd(2'd3, hi);
    chk("R9 product 12x34", {hi, lo}, 16'h03A8);
    do_wr(2'd2, 8'hFF); do_wr(2'd3, 8'hFF);
    do_rd(2'd2, lo); do_rd(2'd3, hi);
    chk("R9 product FFxFF", {hi, lo}, 16'hFE01);
    do_wr(2'd2, 8'h00);
    do_rd(2'd3, hi); do_rd(2'd2, lo);
    chk("R9 product zero", {hi, lo}, 16'h0000);
  endtask

  task automatic t_count;
    logic [7:0] d;
    do_wr(2'd0, 8'd5); do_wr(2'd1, 8'h80);
    do_tick(9'h1FF);
    chk("R3 frame start", peek, 8'h40);
    for (int l = 0; l < 4; l++) do_tick(9'(l));
    chk("R4 below target", peek, 8'h40);
    chk("R8 no irq below target", irq, 1'b0);
    do_tick(9'd4);
    chk("R4 match target", peek, 8'hC0);
    chk("R8 irq on match", irq, 1'b1);
    do_tick(9'd5);
    chk("R4 pending holds", peek, 8'hC0);
    repeat (3) @(negedge clk);
    chk("R7 peek no clear", peek, 8'hC0);
    do_rd(2'd1, d);
    chk("R6 status value", d, 8'hC0);
    chk("R6 cleared after read", peek, 8'h40);
    chk("R8 irq drops", irq, 1'b0);
  endtask

  task automatic t_enable_ext;
    logic [7:0] d;
    do_wr(2'd1, 8'h7F);
    do_wr(2'd0, 8'd8);
    do_tick(9'd6); do_tick(9'd7);
    chk("R4 pending at 8", peek, 8'hC0);
    chk("R5 disabled no irq", irq, 1'b0);
    do_wr(2'd1, 8'h80);
    chk("R5 enable irq", irq, 1'b1);
    do_rd(2'd1, d);
    @(negedge clk); ext = 1'b1; #1;
    chk("R8 ext passthrough", irq, 1'b1);
    @(negedge clk); ext = 1'b0; #1;
    chk("R8 ext released", irq, 1'b0);
  endtask

  task automatic t_blank;
    do_tick(9'd239);
    chk("R2 line 240 in frame", peek, 8'h40);
    do_tick(9'd240);
    chk("R2 vblank clears", peek, 8'h00);
    do_tick(9'h1FF);
    do_wr(2'd0, 8'd1);
    do_tick(9'd0);
    chk("R4 target 1", peek, 8'hC0);
    @(negedge clk); render = 1'b0;
    do_tick(9'd1);
    chk("R2 render off clears", peek, 8'h00);
    chk("R2 irq off", irq, 1'b0);
    @(negedge clk); render = 1'b1;
  endtask

  task automatic t_restart;
    do_wr(2'd0, 8'd2);
    do_tick(9'h1FF);
    do_tick(9'd0);
    chk("R3 count restarted", peek, 8'h40);
    @(negedge clk); render = 1'b0; line = 9'd100;
    repeat (3) @(negedge clk);
    chk("R1 no tick no change", peek, 8'h40);
    render = 1'b1;
    do_tick(9'd1);
    chk("R3 fires at second line", peek, 8'hC0);
  endtask

  task automatic t_race;
    logic [7:0] d;
    do_tick(9'd240);
    do_tick(9'h1FF);
    do_tick(9'd0);
    @(negedge clk); tick = 1'b1; line = 9'd1; rd = 1'b1; addr = 2'd1;
    #1 d = rdata;
    @(negedge clk); tick = 1'b0; rd = 1'b0;
    chk("R6 status before set", d, 8'h40);
    chk("R6 set beats ack", peek, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_count();
    t_enable_ext();
    t_blank();
    t_restart();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule